// File: doc/BRIEF.md
# Table-Driven Delay-and-Sum Scanline Beamformer

This block builds one focused receive scanline from echo samples already stored per channel. It steps through the channels one at a time. For each channel it visits every output sample position. At each position it reads a 16-bit delay word from an external table. The coarse part of that word is used as an offset into the channel's sample memory, and an eight-sample window is gathered from there. The fine part of the word goes, together with the window, to an external interpolator over a request/acknowledge handshake. The interpolated value is scaled by a per-channel apodization weight and added, with saturation, into an internal partial-sum memory.

Once the last channel is done, the partial-sum memory holds the scanline, and the block streams it out one value per cycle. It can add, element by element, a partial sum produced elsewhere for the other half of the aperture, which it reads through its own port. A symmetric mode lets the upper half of the channels reuse the delay rows of their mirror channels, so that only half of the table needs valid data when there is no steering.

Top module: `dasbf_engine`

## Requirements
- R1: While reset is high and after it is released, `done`, `out_valid`, `interp_req`, `dly_rd_en` and `ch_rd_en` are low, and they stay low until `start` is seen.
- R2: Delay word bits [15:3] are an unsigned coarse offset and bits [2:0] are the interpolator phase. Window element k (k = 0..7, element k in `interp_win[k*16 +: 16]`) is sample `offset + k` of the current channel, read at address `channel*DEPTH + offset + k`. `interp_phase` carries the phase.
- R3: A window element whose sample index `offset + k` is DEPTH or more is zero, and no channel memory read is issued for it.
- R4: The partial-sum memory is cleared at every `start`, so a scanline never contains a residue of the previous one.
- R5: Delay-table reads follow the order of all NSAMP output positions for channel 0, then all of them for channel 1, and so on. Each read is at address `row*NSAMP + n`.
- R6: Each interpolated value r is weighted as floor(r*w/128), where w is the unsigned 8-bit weight `apod_w[m*8 +: 8]` of channel m, so a weight of 128 means unity.
- R7: Every accumulation clamps to the signed AW-bit range. The channels are added in ascending order.
- R8: With `sym_en` high, channel m ≥ NCH/2 uses delay row NCH-1-m. Otherwise channel m uses row m.
- R9: With `merge_en` high, output n is the saturated sum of the partial sum n and `ext_rd_data`, which arrives one cycle after `ext_rd_addr` = n. With `merge_en` low, output n is the partial sum n alone.
- R10: The scanline leaves as NSAMP consecutive `out_valid` cycles in the order n = 0 upward. `done` is high for exactly one cycle, the cycle after the last beat.
- R11: `interp_req` stays high, with `interp_win` and `interp_phase` held steady, until the cycle in which `interp_ack` is high. `interp_res` is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scanline when idle |
| sym_en | input | 1 | Mirror delay rows for the upper half of the channels |
| merge_en | input | 1 | Add the other half-aperture's partial sum at output |
| apod_w | input | NCH*8 | Per-channel weights, unity = 128 |
| done | output | 1 | One-cycle pulse after the last output beat |
| dly_rd_en | output | 1 | Delay table read strobe |
| dly_rd_addr | output | log2(NCH*NSAMP) | Delay table address |
| dly_rd_data | input | 16 | Delay word, valid one cycle after the read |
| ch_rd_en | output | 1 | Channel memory read strobe |
| ch_rd_addr | output | log2(NCH*DEPTH) | Channel memory address |
| ch_rd_data | input | 16 | Channel sample, valid one cycle after the read |
| interp_req | output | 1 | Interpolation request |
| interp_win | output | 8*16 | Eight-sample window |
| interp_phase | output | 3 | Fine delay phase |
| interp_ack | input | 1 | Interpolator result valid |
| interp_res | input | AW | Interpolated sample |
| ext_rd_addr | output | log2(NSAMP) | Read address for the external partial sum |
| ext_rd_data | input | AW | External partial sum, one cycle latency |
| out_valid | output | 1 | Scanline sample valid |
| out_data | output | AW | Scanline sample |

## Verification
Saturation and the half-aperture merge can act on the same output beat: the partial sum may already be clamped when the external sum is added, and that addition clamps again. The bench provokes this with full-scale negative samples, maximum weights and a full-scale negative external sum. It then checks every beat against a model that clamps after each channel and again after the merge. Symmetric row mapping and window truncation are checked in the same way, with each expected value built independently from the delay rule.

// File: rtl/dasbf_pkg.sv
package dasbf_pkg;
  localparam int DLY_BITS  = 16;
  localparam int FRAC_BITS = 3;
  localparam int INT_BITS  = DLY_BITS - FRAC_BITS;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR, ST_LUT, ST_DLY, ST_FETCH, ST_REQ, ST_ACC, ST_OUT, ST_FIN
  } bf_state_t;
endpackage

// File: rtl/dasbf_psum_ram.sv
module dasbf_psum_ram #(
  parameter int W  = 18,
  parameter int N  = 8,
  parameter int AB = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AB-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AB-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [N];

  // single write port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dasbf_sat_acc.sv
module dasbf_sat_acc #(
  parameter int AW = 18,
  parameter int RW = 18,
  parameter int WW = 8
) (
  input  logic signed [AW-1:0] acc,
  input  logic signed [RW-1:0] res,
  input  logic        [WW-1:0] wgt,
  output logic signed [AW-1:0] sum
);
  localparam int PW = RW + WW + 2;
  localparam logic signed [PW-1:0] MAXV = {{(PW-AW+1){1'b0}}, {(AW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-AW+1){1'b1}}, {(AW-1){1'b0}}};

  logic signed [RW+WW:0] prod;
  logic signed [PW-1:0]  scaled;
  logic signed [PW-1:0]  total;

  always_comb begin
    prod   = res * $signed({1'b0, wgt});
    scaled = PW'(prod >>> (WW-1));
    total  = scaled + PW'(acc);
    if (total > MAXV)      sum = AW'(MAXV);
    else if (total < MINV) sum = AW'(MINV);
    else                   sum = AW'(total);
  end

  // R7
  always_comb begin
    if (!scaled[PW-1] && !acc[AW-1]) no_wrap_pos_chk: assert (!sum[AW-1]);
    if (scaled[PW-1] && acc[AW-1])   no_wrap_neg_chk: assert (sum[AW-1]);
  end
endmodule

// File: rtl/dasbf_window_fetch.sv
module dasbf_window_fetch #(
  parameter int DW    = 16,
  parameter int TAPS  = 8,
  parameter int DEPTH = 32,
  parameter int NCH   = 4,
  parameter int IW    = 13,
  parameter int MW    = $clog2(NCH),
  parameter int CAW   = $clog2(NCH*DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [IW-1:0]      base,
  input  logic [MW-1:0]      chan,
  output logic               ch_rd_en,
  output logic [CAW-1:0]     ch_rd_addr,
  input  logic [DW-1:0]      ch_rd_data,
  output logic [TAPS*DW-1:0] win,
  output logic               done
);
  localparam int KW = $clog2(TAPS);

  logic          busy;
  logic [KW-1:0] k;
  logic [IW-1:0] base_q;
  logic [MW-1:0] chan_q;
  logic [IW:0]   idx;
  logic          in_range;
  logic          cap_en;
  logic          cap_zero;
  logic [KW-1:0] cap_k;

  always_comb begin
    idx        = {1'b0, base_q} + (IW+1)'(k);
    in_range   = idx < (IW+1)'(DEPTH);
    ch_rd_en   = busy && in_range;
    ch_rd_addr = CAW'(chan_q) * CAW'(DEPTH) + CAW'(idx);
  end

  // issue stage: one sample address per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      k        <= '0;
      base_q   <= '0;
      chan_q   <= '0;
      cap_en   <= 1'b0;
      cap_zero <= 1'b0;
      cap_k    <= '0;
    end else begin
      cap_en   <= busy;
      cap_k    <= k;
      cap_zero <= !in_range;
      if (go) begin
        busy   <= 1'b1;
        k      <= '0;
        base_q <= base;
        chan_q <= chan;
      end else if (busy) begin
        k <= k + 1'b1;
        if (k == KW'(TAPS-1)) busy <= 1'b0;
      end
    end
  end

  // capture stage: memory data arrives one cycle after its address
  always_ff @(posedge clk) begin
    if (rst) begin
      win  <= '0;
      done <= 1'b0;
    end else begin
      done <= cap_en && (cap_k == KW'(TAPS-1));
      if (cap_en) win[cap_k*DW +: DW] <= cap_zero ? '0 : ch_rd_data;
    end
  end

  // R2
  fetch_idle_chk: assert property (@(posedge clk) disable iff (rst) go |-> !busy);
endmodule

// File: rtl/dasbf_engine.sv
module dasbf_engine
  import dasbf_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int NSAMP = 8,
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int AW    = 18,
  parameter int WW    = 8,
  parameter int TAPS  = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic                             sym_en,
  input  logic                             merge_en,
  input  logic [NCH*WW-1:0]                apod_w,
  output logic                             done,
  output logic                             dly_rd_en,
  output logic [$clog2(NCH*NSAMP)-1:0]     dly_rd_addr,
  input  logic [15:0]                      dly_rd_data,
  output logic                             ch_rd_en,
  output logic [$clog2(NCH*DEPTH)-1:0]     ch_rd_addr,
  input  logic [DW-1:0]                    ch_rd_data,
  output logic                             interp_req,
  output logic [TAPS*DW-1:0]               interp_win,
  output logic [FRAC_BITS-1:0]             interp_phase,
  input  logic                             interp_ack,
  input  logic [AW-1:0]                    interp_res,
  output logic [$clog2(NSAMP)-1:0]         ext_rd_addr,
  input  logic [AW-1:0]                    ext_rd_data,
  output logic                             out_valid,
  output logic [AW-1:0]                    out_data
);
  localparam int DAW = $clog2(NCH*NSAMP);
  localparam int CAW = $clog2(NCH*DEPTH);
  localparam int NAW = $clog2(NSAMP);
  localparam int MW  = $clog2(NCH);
  localparam logic [NAW-1:0] N_LAST = NAW'(NSAMP-1);
  localparam logic [MW-1:0]  M_LAST = MW'(NCH-1);
  localparam logic [WW-1:0]  UNITY  = {1'b1, {(WW-1){1'b0}}};

  bf_state_t           state;
  logic [MW-1:0]       m;
  logic [NAW-1:0]      n;
  logic [MW-1:0]       row;
  logic [FRAC_BITS-1:0] phase_q;
  logic [AW-1:0]       res_q;
  logic [WW-1:0]       w_cur;
  logic                fetch_go;
  logic                fetch_done;
  logic                psum_we;
  logic [AW-1:0]       psum_wdata;
  logic [AW-1:0]       psum_rdata;
  logic [AW-1:0]       acc_sum;
  logic [AW-1:0]       mrg_sum;
  logic                rd_v1, rd_l1, rd_l2;

  // row selection: mirror upper half of the aperture in symmetric mode
  always_comb begin
    row = (sym_en && (m >= MW'(NCH/2))) ? (M_LAST - m) : m;
    w_cur = apod_w[m*WW +: WW];
  end

  assign dly_rd_en    = (state == ST_LUT);
  assign dly_rd_addr  = DAW'(row) * DAW'(NSAMP) + DAW'(n);
  assign fetch_go     = (state == ST_DLY);
  assign interp_req   = (state == ST_REQ);
  assign interp_phase = phase_q;
  assign ext_rd_addr  = n;
  assign psum_we      = (state == ST_CLR) || (state == ST_ACC);
  assign psum_wdata   = (state == ST_CLR) ? '0 : acc_sum;

  dasbf_window_fetch #(
    .DW(DW), .TAPS(TAPS), .DEPTH(DEPTH), .NCH(NCH), .IW(INT_BITS), .MW(MW), .CAW(CAW)
  ) u_fetch (
    .clk(clk), .rst(rst), .go(fetch_go),
    .base(dly_rd_data[DLY_BITS-1:FRAC_BITS]), .chan(m),
    .ch_rd_en(ch_rd_en), .ch_rd_addr(ch_rd_addr), .ch_rd_data(ch_rd_data),
    .win(interp_win), .done(fetch_done)
  );

  dasbf_psum_ram #(.W(AW), .N(NSAMP), .AB(NAW)) u_psum (
    .clk(clk), .we(psum_we), .waddr(n), .wdata(psum_wdata),
    .raddr(n), .rdata(psum_rdata)
  );

  dasbf_sat_acc #(.AW(AW), .RW(AW), .WW(WW)) u_acc (
    .acc(psum_rdata), .res(res_q), .wgt(w_cur), .sum(acc_sum)
  );

  dasbf_sat_acc #(.AW(AW), .RW(AW), .WW(WW)) u_merge (
    .acc(psum_rdata), .res(ext_rd_data), .wgt(UNITY), .sum(mrg_sum)
  );

  // sequencer: clear, then channel-major sweep, then stream out
  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      m       <= '0;
      n       <= '0;
      phase_q <= '0;
      res_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_CLR;
          m     <= '0;
          n     <= '0;
        end
        ST_CLR: begin
          if (n == N_LAST) begin
            n     <= '0;
            state <= ST_LUT;
          end else begin
            n <= n + 1'b1;
          end
        end
        ST_LUT: state <= ST_DLY;
        ST_DLY: begin
          phase_q <= dly_rd_data[FRAC_BITS-1:0];
          state   <= ST_FETCH;
        end
        ST_FETCH: if (fetch_done) state <= ST_REQ;
        ST_REQ: if (interp_ack) begin
          res_q <= interp_res;
          state <= ST_ACC;
        end
        ST_ACC: begin
          if (n == N_LAST) begin
            n <= '0;
            if (m == M_LAST) begin
              m     <= '0;
              state <= ST_OUT;
            end else begin
              m     <= m + 1'b1;
              state <= ST_LUT;
            end
          end else begin
            n     <= n + 1'b1;
            state <= ST_LUT;
          end
        end
        ST_OUT: begin
          if (n == N_LAST) begin
            n     <= '0;
            state <= ST_FIN;
          end else begin
            n <= n + 1'b1;
          end
        end
        ST_FIN: if (rd_l2) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // output pipeline: RAM read, then registered merge
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v1     <= 1'b0;
      rd_l1     <= 1'b0;
      rd_l2     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
    end else begin
      rd_v1     <= (state == ST_OUT);
      rd_l1     <= (state == ST_OUT) && (n == N_LAST);
      rd_l2     <= rd_l1;
      out_valid <= rd_v1;
      out_data  <= rd_v1 ? (merge_en ? mrg_sum : psum_rdata) : out_data;
      done      <= rd_l2;
    end
  end

  // R11
  interp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    interp_req && !interp_ack |=> interp_req && $stable(interp_phase) && $stable(interp_win));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R10
  out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !interp_req && !dly_rd_en && !ch_rd_en);
endmodule

// File: tb/dasbf_engine_bench.sv
module dasbf_engine_bench;
  localparam int NCH = 4, NSAMP = 8, DEPTH = 32, DW = 16, AW = 18, WW = 8, TAPS = 8;
  localparam int DAW = $clog2(NCH*NSAMP), CAW = $clog2(NCH*DEPTH), NAW = $clog2(NSAMP);
  localparam longint SMAX = (longint'(1) <<< (AW-1)) - 1;
  localparam longint SMIN = -(longint'(1) <<< (AW-1));

  // {seed, weight base, ack delay, flags: [0]sym [1]merge [2]full-scale [3]out-of-range}
  localparam logic [31:0] VECS [8] = '{
    32'h01_80_00_00, 32'h02_C8_03_00, 32'h03_80_02_01, 32'h04_5A_01_02,
    32'h06_FF_00_04, 32'h07_FF_02_06, 32'h05_00_01_00, 32'h08_80_00_08
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, start, sym_en, merge_en;
  logic [NCH*WW-1:0] apod_w;
  logic done, dly_rd_en, ch_rd_en, interp_req, interp_ack, out_valid;
  logic [DAW-1:0] dly_rd_addr;
  logic [15:0] dly_rd_data;
  logic [CAW-1:0] ch_rd_addr;
  logic [DW-1:0] ch_rd_data;
  logic [TAPS*DW-1:0] interp_win;
  logic [2:0] interp_phase;
  logic [AW-1:0] interp_res, ext_rd_data, out_data;
  logic [NAW-1:0] ext_rd_addr;

  logic [15:0]   dlymem [NCH*NSAMP];
  logic [DW-1:0] chmem  [NCH*DEPTH];
  logic [AW-1:0] extmem [NSAMP];
  longint exp_out [NSAMP];

  int nchk = 0, nfail = 0, hs_err = 0, ack_dly = 0, ack_cnt = 0;
  bit finished = 0, holding = 0;
  logic [2:0] held_phase;

  dasbf_engine #(.NCH(NCH), .NSAMP(NSAMP), .DEPTH(DEPTH), .DW(DW), .AW(AW), .WW(WW), .TAPS(TAPS))
  u_dasbf_engine (
    .clk(clk), .rst(rst), .start(start), .sym_en(sym_en), .merge_en(merge_en), .apod_w(apod_w),
    .done(done), .dly_rd_en(dly_rd_en), .dly_rd_addr(dly_rd_addr), .dly_rd_data(dly_rd_data),
    .ch_rd_en(ch_rd_en), .ch_rd_addr(ch_rd_addr), .ch_rd_data(ch_rd_data),
    .interp_req(interp_req), .interp_win(interp_win), .interp_phase(interp_phase),
    .interp_ack(interp_ack), .interp_res(interp_res),
    .ext_rd_addr(ext_rd_addr), .ext_rd_data(ext_rd_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // memories with one cycle read latency
  always @(posedge clk) begin
    dly_rd_data <= dlymem[dly_rd_addr];
    ch_rd_data  <= chmem[ch_rd_addr];
    ext_rd_data <= extmem[ext_rd_addr];
  end

  // interpolator model: picks window element selected by phase
  always @(posedge clk) begin
    if (rst) begin
      interp_ack <= 1'b0; interp_res <= '0; ack_cnt <= 0; holding <= 0;
    end else if (interp_ack) begin
      interp_ack <= 1'b0; holding <= 0;
    end else if (interp_req) begin
      if (holding && interp_phase != held_phase) hs_err <= hs_err + 1;
      holding <= 1; held_phase <= interp_phase;
      if (ack_cnt == ack_dly) begin
        interp_ack <= 1'b1;
        interp_res <= AW'($signed(interp_win[interp_phase*DW +: DW]));
        ack_cnt <= 0;
      end else ack_cnt <= ack_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic longint sval(input int seed, input int m, input int i, input bit amp);
    if (amp) return seed[0] ? -32768 : 32767;
    return longint'((m*37 + i*13 + seed*7) % 401) - 200;
  endfunction

  function automatic int dint(input int seed, input int r, input int n, input bit oor);
    if (oor) return DEPTH + 1;
    return (n*3 + r*5 + seed) % 34;
  endfunction

  function automatic longint wgt(input int wb, input int m);
    if (wb == 0) return 0;
    return longint'((wb - m*8) & 255);
  endfunction

  task automatic run_case(input logic [31:0] v);
    int seed = int'(v[31:24]);
    int wb = int'(v[23:16]);
    bit sym = v[0], mrg = v[1], amp = v[2], oor = v[3];
    string tag;
    int beat = 0, first_beat = -1, last_beat = -1, done_at = -1, dones = 0;
    int oerr = 0, ocnt = 0, mm = 0, nn = 0;
    tag = sym ? "R8" : mrg ? "R9" : amp ? "R7" : oor ? "R3" : (wb == 0) ? "R4" : (wb != 128) ? "R6" : "R2";
    ack_dly = int'(v[15:8]);
    sym_en = sym; merge_en = mrg;
    for (int r = 0; r < NCH; r++)
      for (int n = 0; n < NSAMP; n++) begin
        int sd = (sym && r >= NCH/2) ? seed + 50 : seed;
        dlymem[r*NSAMP+n] = {13'(dint(sd, r, n, oor)), 3'((n + r + sd) % 8)};
      end
    for (int m = 0; m < NCH; m++) begin
      apod_w[m*WW +: WW] = WW'(wgt(wb, m));
      for (int i = 0; i < DEPTH; i++) chmem[m*DEPTH+i] = DW'(sval(seed, m, i, amp));
    end
    for (int n = 0; n < NSAMP; n++) begin
      longint acc = 0;
      extmem[n] = amp ? (seed[0] ? AW'(SMIN) : AW'(SMAX)) : AW'(n*1000 - 3000);
      for (int m = 0; m < NCH; m++) begin
        int r = (sym && m >= NCH/2) ? NCH-1-m : m;
        int idx = dint(seed, r, n, oor) + (n + r + seed) % 8;
        longint s = (idx < DEPTH) ? sval(seed, m, idx, amp) : 0;
        acc = sat(acc + ((s * wgt(wb, m)) >>> 7));
      end
      exp_out[n] = mrg ? sat(acc + longint'($signed(extmem[n]))) : acc;
    end
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if (dly_rd_en) begin
        int r = (sym && mm >= NCH/2) ? NCH-1-mm : mm;
        if (dly_rd_addr != DAW'(r*NSAMP + nn)) oerr++;
        ocnt++; nn++;
        if (nn == NSAMP) begin nn = 0; mm++; end
      end
      if (out_valid) begin
        if (beat < NSAMP)
          chk(longint'($signed(out_data)) == exp_out[beat], tag, longint'($signed(out_data)), exp_out[beat]);
        if (first_beat < 0) first_beat = c;
        beat++; last_beat = c;
      end
      if (done) begin dones++; if (done_at < 0) done_at = c; end
      if (done_at >= 0 && c > done_at + 3) break;
    end
    // R10 beat count, contiguity, and done timing
    chk(beat == NSAMP && last_beat - first_beat == NSAMP-1, "R10 beats", beat, NSAMP);
    chk(dones == 1 && done_at == last_beat + 1, "R10 done", done_at, last_beat + 1);
    // R5 channel-major delay table order
    chk(oerr == 0 && ocnt == NCH*NSAMP, "R5 order", oerr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; sym_en = 1'b0; merge_en = 1'b0; apod_w = '0;
    for (int i = 0; i < NSAMP; i++) extmem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !out_valid && !interp_req && !dly_rd_en && !ch_rd_en, "R1 in reset",
        {done, out_valid, interp_req, dly_rd_en, ch_rd_en}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(!done && !out_valid && !interp_req && !dly_rd_en && !ch_rd_en, "R1 idle",
        {done, out_valid, interp_req, dly_rd_en, ch_rd_en}, 0);

    for (int i = 0; i < 8; i++) run_case(VECS[i]);

    // R4 directed: repeat a nonzero scanline back to back, must match fresh model
    run_case(VECS[1]);
    run_case(VECS[1]);

    // R1 directed: reset in mid-scanline returns the block to quiet idle
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done && !out_valid && !interp_req && !dly_rd_en && !ch_rd_en, "R1 mid reset",
        {done, out_valid, interp_req, dly_rd_en, ch_rd_en}, 0);
    run_case(VECS[0]);

    // R11 phase held while waiting for acknowledge
    chk(hs_err == 0, "R11 hold", hs_err, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule